// File: doc/BRIEF.md
# Peripheral Input Pin Remapper

This block lets software decide which package pin drives each digital peripheral input. Each peripheral input has its own small select register. The register holds a pin number, and a multiplexer routes the named pin's input level to that peripheral. The sources form one numbered space:

- Numbers 0 to 31 are the input side of the bidirectional remappable pins.
- Numbers 32 to 45 are the pins that can only be inputs.

After reset no peripheral input is tied to any pin. Every select holds an unused code, and every routed output sits at a fixed inactive level until software names a pin. Any code above the last pin also routes the inactive level.

Software programs and reads back the selects through a simple synchronous register port. One address selects one peripheral input. Routing from pin to peripheral is purely combinational, so a pin change reaches the peripheral in the same cycle. The block does not synchronise pins and does not model pads.

Top module: `pin_input_remap`

## Requirements
- R1: After reset every select register reads back 0x3F, and every peripheral output is 0 whatever the pins carry.
- R2: When `regWr` is 1 at a rising clock edge, `regWdata[5:0]` is loaded into the select register numbered by `regAddr`. `regRdata` always shows the select register numbered by `regAddr`, without a clock.
- R3: A select value from 0 to 31 routes `pinIn[value]`, a bidirectional pin's input, to that peripheral output.
- R4: A select value from 32 to 45 routes `pinIn[value]`, an input-only pin, to that peripheral output.
- R5: A select value from 46 to 63 drives that peripheral output to the inactive level 0, whatever the pins carry.
- R6: A change on a selected pin appears on the peripheral output in the same cycle, with no register in the path.
- R7: A write changes only the addressed select. Several peripheral inputs may name the same pin, and each of them then follows that pin.
- R8: While `regWr` is 0, every select register holds its value, whatever `regAddr` and `regWdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Write strobe for the select registers |
| regAddr | input | 3 | Index of the peripheral input to write or read |
| regWdata | input | 6 | Pin number to store |
| regRdata | output | 6 | Select register of the addressed peripheral input |
| pinIn | input | 46 | Pin input levels; bits 0-31 are bidirectional pins, bits 32-45 are input-only pins |
| periphIn | output | 8 | Routed level for each peripheral input |

## Verification
The bench builds the block with its default parameters: 32 bidirectional pins, 14 input-only pins, eight selects and a 6-bit select field. This places codes 46 to 63 in the unused range, so every one of the 64 codes can be driven into a select and checked against both a single set pin and a single cleared pin. Two selects point at the same pin to show sharing. A pattern sweep runs with all eight selects spread over the bidirectional range, the input-only range and the unused range. Writes that are not strobed, aimed at every address, confirm that nothing moves.

// File: rtl/pin_remap_pkg.sv
package pin_remap_pkg;
  // width of the index fields carried from control to datapath
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             wrStrobe;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
  } remapStrobe_t;
endpackage

// File: rtl/pin_remap_ctrl.sv
module pin_remap_ctrl
  import pin_remap_pkg::*;
#(
  parameter int NUM_SEL = 8,
  parameter int SEL_W   = 6,
  localparam int ADDR_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SEL_W-1:0]  regWdata,
  output remapStrobe_t      strb,
  output logic [SEL_W-1:0]  wrData
);
  logic addrOk;

  // addresses past the last select are dropped
  assign addrOk = ({1'b0, regAddr} < (ADDR_W+1)'(NUM_SEL));

  always_comb begin
    strb          = '0;
    strb.wrStrobe = regWr && addrOk;
    strb.wrIdx    = IDX_W'(regAddr);
    strb.rdIdx    = IDX_W'(regAddr);
  end

  assign wrData = regWdata;
endmodule

// File: rtl/pin_remap_dp.sv
module pin_remap_dp
  import pin_remap_pkg::*;
#(
  parameter int   NUM_IO      = 32,
  parameter int   NUM_IN_ONLY = 14,
  parameter int   NUM_SEL     = 8,
  parameter int   SEL_W       = 6,
  parameter logic IDLE_LEVEL  = 1'b0,
  localparam int  NUM_PINS    = NUM_IO + NUM_IN_ONLY,
  localparam int  CODES       = 1 << SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  remapStrobe_t        strb,
  input  logic [SEL_W-1:0]    wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_SEL-1:0]  periphIn,
  output logic [SEL_W-1:0]    rdData
);
  localparam logic [SEL_W-1:0] UNUSED_CODE = '1;

  logic [SEL_W-1:0]   selQ [NUM_SEL];
  logic [NUM_SEL-1:0] wrHit;
  logic [CODES-1:0]   srcVec;

  // pin space padded to the full code range with the idle level
  always_comb begin
    srcVec = {CODES{IDLE_LEVEL}};
    srcVec[NUM_PINS-1:0] = pinIn;
  end

  generate
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
      assign wrHit[i] = strb.wrStrobe && (strb.wrIdx == IDX_W'(i));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         selQ[i] <= UNUSED_CODE;
        else if (wrHit[i]) selQ[i] <= wrData;
      end

      assign periphIn[i] = srcVec[selQ[i]];

      // R2
      write_load_chk: assert property (@(posedge clk) disable iff (!rstN)
        wrHit[i] |=> (selQ[i] == $past(wrData)));

      // R8
      sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !wrHit[i] |=> $stable(selQ[i]));

      // R5
      unused_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        ({1'b0, selQ[i]} >= (SEL_W+1)'(NUM_PINS)) |-> (periphIn[i] == IDLE_LEVEL));

      // R3
      routed_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
        ({1'b0, selQ[i]} < (SEL_W+1)'(NUM_PINS)) |-> (periphIn[i] == pinIn[selQ[i]]));
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_SEL; i++)
      if (strb.rdIdx == IDX_W'(i)) rdData = selQ[i];
  end

  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrHit));
endmodule

// File: rtl/pin_input_remap.sv
module pin_input_remap
  import pin_remap_pkg::*;
#(
  parameter int   NUM_IO      = 32,
  parameter int   NUM_IN_ONLY = 14,
  parameter int   NUM_SEL     = 8,
  parameter int   SEL_W       = 6,
  parameter logic IDLE_LEVEL  = 1'b0,
  localparam int  NUM_PINS    = NUM_IO + NUM_IN_ONLY,
  localparam int  ADDR_W      = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [SEL_W-1:0]    regWdata,
  output logic [SEL_W-1:0]    regRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_SEL-1:0]  periphIn
);
  remapStrobe_t     strb;
  logic [SEL_W-1:0] wrData;

  pin_remap_ctrl #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_ctrl (
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .strb(strb), .wrData(wrData)
  );

  pin_remap_dp #(
    .NUM_IO(NUM_IO), .NUM_IN_ONLY(NUM_IN_ONLY), .NUM_SEL(NUM_SEL),
    .SEL_W(SEL_W), .IDLE_LEVEL(IDLE_LEVEL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .pinIn(pinIn), .periphIn(periphIn), .rdData(regRdata)
  );
endmodule

// File: tb/tb_pin_input_remap.sv
module tb_pin_input_remap;
  localparam int NP = 46;
  localparam int NS = 8;

  logic          clk = 0;
  logic          rstN = 0;
  logic          regWr = 0;
  logic [2:0]    regAddr = 0;
  logic [5:0]    regWdata = 0;
  logic [5:0]    regRdata;
  logic [NP-1:0] pinIn = '0;
  logic [NS-1:0] periphIn;

  pin_input_remap dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn), .periphIn(periphIn)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    string         tag;
    logic [NS-1:0] expOut;
    logic [5:0]    expRd;
  } item_t;

  item_t  sbq[$];
  int     nRun = 0, nFail = 0;
  bit     done = 0;
  logic [5:0] selModel [NS];

  // monitor: pop expected items and compare with the ports
  initial begin
    forever begin
      wait (sbq.size() != 0);
      begin
        item_t it;
        it = sbq.pop_front();
        nRun++;
        if (periphIn !== it.expOut || regRdata !== it.expRd) begin
          nFail++;
          $display("FAIL %s: out=%b rd=%h expected out=%b rd=%h",
                   it.tag, periphIn, regRdata, it.expOut, it.expRd);
        end
      end
    end
  end

  function automatic logic [NS-1:0] model_out(logic [NP-1:0] p);
    logic [NS-1:0] o;
    for (int i = 0; i < NS; i++) o[i] = (selModel[i] < NP) ? p[selModel[i]] : 1'b0;
    return o;
  endfunction

  // driver: apply pins and address, push expected, let monitor compare
  task automatic check(string tag, logic [NP-1:0] p, int a);
    item_t it;
    @(negedge clk);
    pinIn = p;
    regAddr = 3'(a);
    #2;
    it.tag = tag;
    it.expOut = model_out(p);
    it.expRd = selModel[a];
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic wr(int a, logic [5:0] v);
    @(negedge clk);
    regWr = 1; regAddr = 3'(a); regWdata = v;
    @(negedge clk);
    regWr = 0;
    selModel[a] = v;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) selModel[i] = 6'h3F;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: reset contents and idle outputs with all pins high
    for (int a = 0; a < NS; a++) check("R1", '1, a);

    // R3 R4 R5: every code on select 0, one pin set then one pin cleared
    for (int c = 0; c < 64; c++) begin
      string t;
      logic [NP-1:0] one;
      t = (c < 32) ? "R3" : (c < NP) ? "R4" : "R5";
      one = (c < NP) ? (NP'(1) << c) : '0;
      wr(0, 6'(c));
      check(t, one, 0);
      check(t, ~one, 0);
    end

    // R2 R7: spread selects over all ranges, two share pin 5
    wr(0, 6'd0);  wr(1, 6'd31); wr(2, 6'd32); wr(3, 6'd45);
    wr(4, 6'd46); wr(5, 6'd63); wr(6, 6'd5);  wr(7, 6'd5);
    for (int a = 0; a < NS; a++) check("R2", '1, a);
    for (int p = 0; p < 12; p++) begin
      logic [NP-1:0] v;
      v = NP'(64'h2D3C_4B5A_6978 * (p + 1)) ^ (NP'(p) << 30);
      check("R7", v, p % NS);
    end

    // R6: pin toggles seen in the same cycle, no clock edge between
    @(negedge clk);
    pinIn = '0; regAddr = 3'd6;
    #2 sbq.push_back('{tag:"R6", expOut:model_out('0), expRd:6'd5});
    wait (sbq.size() == 0);
    pinIn[5] = 1'b1; pinIn[45] = 1'b1;
    #1 sbq.push_back('{tag:"R6", expOut:model_out(pinIn), expRd:6'd5});
    wait (sbq.size() == 0);

    // R7: rewriting one select leaves the others
    wr(6, 6'd40);
    for (int a = 0; a < NS; a++) check("R7", 46'h2AAA_5555_F0F0, a);

    // R8: unstrobed data at every address changes nothing
    for (int a = 0; a < NS; a++) begin
      @(negedge clk);
      regAddr = 3'(a); regWdata = 6'(a + 9);
      @(negedge clk);
    end
    for (int a = 0; a < NS; a++) check("R8", 46'h1555_AAAA_0F0F, a);

    // R1: reset again in mid operation
    @(negedge clk) rstN = 0;
    for (int i = 0; i < NS; i++) selModel[i] = 6'h3F;
    @(negedge clk) rstN = 1;
    check("R1", '1, 3);
    check("R1", '1, 7);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: run=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule